// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Checking

This block is a small, fully associative cache of address mappings for 4 KiB pages. A requester presents a virtual address together with two qualifiers: whether the access is a write, and whether it comes from user or supervisor mode. One cycle later the block answers with one of three outcomes. A hit gives the physical address and the page's cacheability. A miss means no valid entry holds that page. A fault means an entry matched but its permissions forbid this access.

Each entry keeps a page tag, a frame number, four permission bits, a cacheable flag, and two status bits. The accessed status bit is set by every hit. The dirty status bit is set only by a write that is allowed. The response reports the values both status bits had just before the access, so software can see how a page has been used.

Maintenance software uses three inputs. A fill input writes an entry in the slot chosen by a round-robin pointer. An invalidate input removes one page by its tag. A flush input empties the whole buffer in a single cycle. Requests and responses use valid/ready handshakes.

Top module: `vxt_tlb`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0, `req_ready` is 1, and every entry is invalid, so the first lookup misses.
- R2: On a permitted hit, `rsp_paddr` is the entry's frame number in bits [31:12] concatenated with bits [11:0] of the request address, which pass through unchanged.
- R3: A lookup that matches no valid entry responds with `rsp_miss`=1, `rsp_fault`=0, `rsp_paddr`=0 and `rsp_cacheable`=0.
- R4: Permission bits are bit0 user-read, bit1 user-write, bit2 supervisor-read and bit3 supervisor-write (`req_user`=1 selects user mode). A hit whose selected bit is 0 responds with `rsp_fault`=1, `rsp_miss`=0, `rsp_paddr`=0 and `rsp_cacheable`=0.
- R5: On a permitted hit, `rsp_cacheable` equals the cacheable flag stored with the entry.
- R6: Every hit, including a faulting one, sets the entry's accessed bit. `rsp_was_accessed` reports the value the bit had before that access.
- R7: Only a permitted write sets the entry's dirty bit. `rsp_was_dirty` reports the value the bit had before that access. A faulting write leaves the bit clear.
- R8: Each fill writes the slot named by a pointer that starts at 0 after reset and steps by one per fill, wrapping after the last slot. A filled entry is valid, with its accessed and dirty bits cleared.
- R9: An invalidate request clears the valid bit of the entry whose tag equals `inv_vpn`. Other entries are unaffected.
- R10: A flush clears every valid bit at the next edge. It overrides a fill or an invalidate in the same cycle.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request produces its response on the next cycle. The response is held unchanged while `rsp_ready` is low.
- R12: A lookup accepted in the same cycle as a fill, invalidate or flush sees the table as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | 32 | Physical address (0 on miss or fault) |
| rsp_cacheable | output | 1 | Page may be cached |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_fault | output | 1 | Access denied by permissions |
| rsp_was_accessed | output | 1 | Accessed bit before this access |
| rsp_was_dirty | output | 1 | Dirty bit before this access |
| fill_en | input | 1 | Write a new entry at the round-robin slot |
| fill_vpn | input | 20 | Tag of the new entry |
| fill_pfn | input | 20 | Frame number of the new entry |
| fill_perm | input | 4 | Permission bits (encoding as in R4) |
| fill_cacheable | input | 1 | Cacheable flag of the new entry |
| inv_en | input | 1 | Invalidate the entry matching inv_vpn |
| inv_vpn | input | 20 | Tag to invalidate |
| flush | input | 1 | Clear all valid bits |

## Verification
The hardest case to reach from the ports is a lookup that collides with table maintenance, where the lookup must use the table as it stood before the edge. A close second is checking status bits that the block only reveals in a later response. The stimulus lines up a lookup of a page in the same cycle as its fill, then in the same cycle as its invalidation, and issues a flush together with a fill. Each page is then looked up again so the surviving state appears at the ports. Dirty behaviour is exposed by following each faulting or permitted write with a read of the same page. Eviction is reached by filling one more page than there are slots. A backpressure phase holds `rsp_ready` low with a second request waiting.

// File: rtl/vxt_pkg.sv
// Shared types for the translation buffer: permission layout and helper.
// Assumes the permission nibble order user-read at bit 0 up to supervisor-write at bit 3.
package vxt_pkg;

    typedef struct packed {
        logic sup_wr;
        logic sup_rd;
        logic usr_wr;
        logic usr_rd;
    } perm_t;

endpackage

// File: rtl/vxt_match.sv
// Tag comparator array: compares one key against every entry tag in parallel.
// Assumes at most one valid entry holds any given tag (software keeps them unique);
// when several match, the lowest index is reported.
module vxt_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid_vec,
    input  logic [VPN_W-1:0] tags [N],
    input  logic [VPN_W-1:0] key,
    output logic [N-1:0]     hit_vec,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    // Per-entry equality compare, one comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tags[g] == key);
    end

    assign hit = |hit_vec;

    // Priority encode the hit vector, lowest index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/vxt_perm_check.sv
// Permission check: decides whether an access of the given mode and direction
// is allowed by an entry's permission bits. Purely combinational.
module vxt_perm_check
    import vxt_pkg::*;
(
    input  perm_t perm,
    input  logic  is_user,
    input  logic  is_write,
    output logic  allow
);

    // Select the one permission bit that governs this access.
    always_comb begin
        unique case ({is_user, is_write})
            2'b00:   allow = perm.sup_rd;
            2'b01:   allow = perm.sup_wr;
            2'b10:   allow = perm.usr_rd;
            default: allow = perm.usr_wr;
        endcase
    end

endmodule

// File: rtl/vxt_fill_ptr.sv
// Round-robin victim pointer: names the slot the next fill will overwrite.
// Assumes one advance per fill; wraps after slot N-1.
module vxt_fill_ptr #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    // Step the pointer on each fill, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ptr <= '0;
        else if (adv)                 ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
    end

    // Pointer only moves on a fill.
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));

endmodule

// File: rtl/vxt_tlb.sv
// Fully associative translation buffer with per-entry access checks and
// in-place accessed/dirty tracking. One-cycle registered lookup with valid/ready
// on both request and response. Maintenance (fill, invalidate, flush) takes effect
// at the edge and never alters the result of a lookup accepted in the same cycle.
// Assumes software never holds two valid entries with the same tag.
module vxt_tlb
    import vxt_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int OFF_W = 12,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_cacheable,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic             rsp_was_accessed,
    output logic             rsp_was_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [3:0]       fill_perm,
    input  logic             fill_cacheable,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush
);

    // Entry storage.
    logic [N-1:0]     ent_valid;
    logic [N-1:0]     ent_acc;
    logic [N-1:0]     ent_dirty;
    logic [N-1:0]     ent_cach;
    logic [VPN_W-1:0] ent_vpn  [N];
    logic [PFN_W-1:0] ent_pfn  [N];
    perm_t            ent_perm [N];

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic [N-1:0]     lk_hit_vec;
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic [N-1:0]     inv_hit_vec;
    logic             inv_hit;
    logic [IDX_W-1:0] inv_idx;
    logic             lk_allow;
    logic [IDX_W-1:0] fill_slot;
    logic             req_fire;
    logic             grant;

    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign req_ready = !rsp_valid || rsp_ready;
    assign req_fire  = req_valid && req_ready;
    assign grant     = lk_hit && lk_allow;

    vxt_match #(.N(N), .VPN_W(VPN_W)) lookup_match_i (
        .valid_vec (ent_valid),
        .tags      (ent_vpn),
        .key       (req_vpn),
        .hit_vec   (lk_hit_vec),
        .hit       (lk_hit),
        .hit_idx   (lk_idx)
    );

    vxt_match #(.N(N), .VPN_W(VPN_W)) inval_match_i (
        .valid_vec (ent_valid),
        .tags      (ent_vpn),
        .key       (inv_vpn),
        .hit_vec   (inv_hit_vec),
        .hit       (inv_hit),
        .hit_idx   (inv_idx)
    );

    vxt_perm_check perm_i (
        .perm     (ent_perm[lk_idx]),
        .is_user  (req_user),
        .is_write (req_write),
        .allow    (lk_allow)
    );

    vxt_fill_ptr #(.N(N)) fill_ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fill_en),
        .ptr   (fill_slot)
    );

    // Register the lookup outcome; hold it until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid        <= 1'b0;
            rsp_paddr        <= '0;
            rsp_cacheable    <= 1'b0;
            rsp_miss         <= 1'b0;
            rsp_fault        <= 1'b0;
            rsp_was_accessed <= 1'b0;
            rsp_was_dirty    <= 1'b0;
        end else if (req_fire) begin
            rsp_valid        <= 1'b1;
            rsp_paddr        <= grant ? {ent_pfn[lk_idx], req_off} : '0;
            rsp_cacheable    <= grant && ent_cach[lk_idx];
            rsp_miss         <= !lk_hit;
            rsp_fault        <= lk_hit && !lk_allow;
            rsp_was_accessed <= lk_hit && ent_acc[lk_idx];
            rsp_was_dirty    <= lk_hit && ent_dirty[lk_idx];
        end else if (rsp_ready) begin
            rsp_valid        <= 1'b0;
        end
    end

    // Update entries: status on hit, then invalidate, then fill, then flush (last wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_acc   <= '0;
            ent_dirty <= '0;
            ent_cach  <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (req_fire && lk_hit_vec[i]) begin
                    ent_acc[i] <= 1'b1;
                    if (lk_allow && req_write) ent_dirty[i] <= 1'b1;
                end
                if (inv_en && inv_hit_vec[i]) ent_valid[i] <= 1'b0;
                if (fill_en && (fill_slot == IDX_W'(i))) begin
                    ent_valid[i] <= 1'b1;
                    ent_acc[i]   <= 1'b0;
                    ent_dirty[i] <= 1'b0;
                    ent_cach[i]  <= fill_cacheable;
                end
                if (flush) ent_valid[i] <= 1'b0;
            end
        end
    end

    // Tag, frame and permission payload of a filled slot (no reset needed).
    always_ff @(posedge clk) begin
        if (fill_en) begin
            ent_vpn[fill_slot]  <= fill_vpn;
            ent_pfn[fill_slot]  <= fill_pfn;
            ent_perm[fill_slot] <= perm_t'(fill_perm);
        end
    end

    // A stalled response must not change.
    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_miss)
                                        && $stable(rsp_fault) && $stable(rsp_cacheable)));

    // Miss and fault never together.
    assert_miss_fault_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_miss && rsp_fault));

    // A refused or missed lookup exposes no address.
    assert_no_addr_on_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_miss || rsp_fault)) |-> (rsp_paddr == '0 && !rsp_cacheable));

    // Flush empties the buffer at the next edge.
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    // Dirty only rises on an accepted permitted write.
    assert_dirty_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_fire && req_write && grant) |=> ((ent_dirty & ~$past(ent_dirty)) == '0));

    // Tags stay unique so a lookup selects one entry.
    assert_unique_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |-> $onehot0(lk_hit_vec));

endmodule

// File: tb/vxt_tlb_tb.sv
// Bench for vxt_tlb: behavioural reference model updated on each edge and
// compared against the outputs at every falling edge.
module vxt_tlb_tb_top;

    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable, rsp_miss, rsp_fault, rsp_was_accessed, rsp_was_dirty;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [3:0]  fill_perm = '0;
    logic        fill_cacheable = 1'b0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    vxt_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_cacheable(rsp_cacheable), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_was_accessed(rsp_was_accessed), .rsp_was_dirty(rsp_was_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_perm(fill_perm), .fill_cacheable(fill_cacheable),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush(flush)
    );

    // Reference model state.
    logic [19:0] m_vpn [NE];
    logic [19:0] m_pfn [NE];
    logic [3:0]  m_perm [NE];
    bit          m_v [NE];
    bit          m_a [NE];
    bit          m_d [NE];
    bit          m_c [NE];
    int          m_ptr;
    bit          m_rv;
    logic [31:0] m_pa;
    bit          m_rc, m_rm, m_rf, m_ra, m_rd;

    always @(posedge clk) begin
        bit rdy, fire, ok, bitsel;
        int hi;
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_a[i] = 0; m_d[i] = 0; end
            m_ptr = 0; m_rv = 0;
            m_pa = '0; m_rc = 0; m_rm = 0; m_rf = 0; m_ra = 0; m_rd = 0;
        end else begin
            rdy = !m_rv || rsp_ready;
            fire = req_valid && rdy;
            hi = -1;
            for (int i = 0; i < NE; i++)
                if (m_v[i] && m_vpn[i] == req_vaddr[31:12]) hi = i;
            if (fire) begin
                m_rv = 1;
                if (hi < 0) begin
                    m_rm = 1; m_rf = 0; m_pa = '0; m_rc = 0; m_ra = 0; m_rd = 0;
                end else begin
                    bitsel = req_user ? (req_write ? m_perm[hi][1] : m_perm[hi][0])
                                      : (req_write ? m_perm[hi][3] : m_perm[hi][2]);
                    ok = bitsel;
                    m_rm = 0; m_rf = !ok;
                    m_pa = ok ? {m_pfn[hi], req_vaddr[11:0]} : 32'h0;
                    m_rc = ok && m_c[hi];
                    m_ra = m_a[hi]; m_rd = m_d[hi];
                    m_a[hi] = 1;
                    if (ok && req_write) m_d[hi] = 1;
                end
            end else if (rsp_ready) m_rv = 0;
            if (inv_en)
                for (int i = 0; i < NE; i++)
                    if (m_v[i] && m_vpn[i] == inv_vpn) m_v[i] = 0;
            if (fill_en) begin
                m_vpn[m_ptr] = fill_vpn; m_pfn[m_ptr] = fill_pfn; m_perm[m_ptr] = fill_perm;
                m_c[m_ptr] = fill_cacheable; m_v[m_ptr] = 1; m_a[m_ptr] = 0; m_d[m_ptr] = 0;
                m_ptr = (m_ptr + 1) % NE;
            end
            if (flush) for (int i = 0; i < NE; i++) m_v[i] = 0;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): got %h expected %h at %0t", tag, phase, got, exp, $time);
        end
    endtask

    // Compare every falling edge once out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
            chk("R11 rsp_valid", 32'(rsp_valid), 32'(m_rv));
            if (m_rv) begin
                chk("R3 miss", 32'(rsp_miss), 32'(m_rm));
                chk("R4 fault", 32'(rsp_fault), 32'(m_rf));
                chk("R2 paddr", rsp_paddr, m_pa);
                chk("R5 cacheable", 32'(rsp_cacheable), 32'(m_rc));
                chk("R6 was_accessed", 32'(rsp_was_accessed), 32'(m_ra));
                chk("R7 was_dirty", 32'(rsp_was_dirty), 32'(m_rd));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic lookup(logic [31:0] va, logic wr, logic usr);
        req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr;
        tick();
        req_valid = 0;
        tick();
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [3:0] pm, logic c);
        fill_en = 1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = pm; fill_cacheable = c;
        tick();
        fill_en = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        #1;
        phase = "R1";
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R1 reset req_ready", 32'(req_ready), 32'h1);
        lookup(32'h1234_5678, 0, 1);

        phase = "R2 R5 R6";
        fill(20'h12345, 20'hABCDE, 4'hF, 1);
        lookup(32'h1234_5678, 0, 1);
        lookup(32'h1234_5FFF, 0, 0);

        phase = "R7";
        lookup(32'h1234_5000, 1, 1);
        lookup(32'h1234_5001, 0, 1);

        phase = "R4 R7";
        fill(20'h00010, 20'h00777, 4'b0101, 0);
        lookup(32'h0001_0123, 1, 1);
        lookup(32'h0001_0123, 0, 1);
        lookup(32'h0001_0123, 1, 0);
        fill(20'h00020, 20'h00888, 4'b1100, 1);
        lookup(32'h0002_0ABC, 0, 1);
        lookup(32'h0002_0ABC, 0, 0);
        lookup(32'h0002_0ABC, 1, 0);
        lookup(32'h0002_0ABC, 0, 0);

        phase = "R8";
        for (int k = 0; k < NE - 2; k++) fill(20'h30000 + 20'(k), 20'h40000 + 20'(k), 4'hF, k[0]);
        lookup(32'h1234_5678, 0, 1);
        fill(20'h50000, 20'h60000, 4'hF, 0);
        lookup(32'h1234_5678, 0, 1);
        lookup(32'h5000_0004, 0, 1);
        lookup(32'h3000_3010, 0, 0);

        phase = "R9";
        inv_en = 1; inv_vpn = 20'h30003; tick(); inv_en = 0;
        lookup(32'h3000_3010, 0, 0);
        lookup(32'h3000_4010, 0, 0);

        phase = "R12";
        req_valid = 1; req_vaddr = 32'h7000_0abc; req_write = 0; req_user = 1;
        fill_en = 1; fill_vpn = 20'h70000; fill_pfn = 20'h0CAFE; fill_perm = 4'hF; fill_cacheable = 1;
        tick();
        req_valid = 0; fill_en = 0;
        tick();
        lookup(32'h7000_0abc, 0, 1);
        req_valid = 1; req_vaddr = 32'h3000_5000; inv_en = 1; inv_vpn = 20'h30005;
        tick();
        req_valid = 0; inv_en = 0;
        tick();
        lookup(32'h3000_5000, 0, 1);

        phase = "R11";
        rsp_ready = 0;
        req_valid = 1; req_vaddr = 32'h7000_0123; req_write = 1; req_user = 0;
        tick();
        req_vaddr = 32'h3000_0044; req_write = 0;
        repeat (3) tick();
        rsp_ready = 1;
        tick();
        req_valid = 0;
        tick(); tick();

        phase = "R10";
        req_valid = 1; req_vaddr = 32'h7000_0001; req_user = 1;
        flush = 1; fill_en = 1; fill_vpn = 20'h71000; fill_pfn = 20'h1; fill_perm = 4'hF;
        tick();
        req_valid = 0; flush = 0; fill_en = 0;
        tick();
        lookup(32'h7000_0001, 0, 1);
        lookup(32'h7100_0001, 0, 1);
        lookup(32'h3000_0001, 0, 1);
        fill(20'h72000, 20'h2, 4'hF, 1);
        lookup(32'h7200_0FFF, 0, 1);
        repeat (2) tick();
        summary();
    end

endmodule